// File: doc/BRIEF.md
# Configuration Space Address/Data Port Bridge

This block lets a host reach the configuration registers of the functions on a single local bus through two IO port locations. A 32-bit address latch sits at one port. A four-byte data window sits at a second, dword-aligned port, and it takes byte, word or dword accesses. When the host touches the window, the bridge splits the latched value into a bus number, a device/function number and a register offset. It then sends one configuration request to the function that was named.

The bridge answers every IO request with exactly one response. If configuration access is switched off, the bus number is foreign, the function is absent or the port is unmapped, the bridge drops writes. Reads in those cases return all-ones at the width of the access. Forwarded reads wait for the target's single read-valid pulse. The bridge masks the data to the access width and holds it on the response port until the host acknowledges it. Two device/function numbers, the bridge's own and one fixed companion function, are always present, whatever the presence input says.

Top module: `cfg_portbridge`

## Requirements
- R1: A dword (size 2) write to the address port (default 0xCF8) stores all 32 bits of write data in the latch. A dword read of that port returns the latch unchanged.
- R2: The latch is zero after reset. While latch bit 31 is clear, data-window writes issue no configuration request, and data-window reads return 0x000000FF for size 0 (byte), 0x0000FFFF for size 1 (word) and 0xFFFFFFFF for size 2 or 3 (dword).
- R3: Latch bits 23:16 hold the bus number, bits 15:8 the device/function number and bits 7:0 the register offset. A bus number other than the bridge's own (default 0) gives the same drop/all-ones result as R2.
- R4: A device/function number whose presence bit is clear gives the R2 drop/all-ones result. Numbers 0 and 8 count as present even when their presence bits are clear.
- R5: For dword accesses the forwarded register offset is latch bits 7:2 followed by two zero bits. For byte and word accesses it is latch bits 7:0 ORed with the window offset (IO port bits 1:0).
- R6: A forwarded read returns the target's read data ANDed with the all-ones value of the access size from R2. Size 3 is handled as a dword.
- R7: A forwarded write issues exactly one single-cycle configuration request. The request carries the write flag, the device/function number, the offset from R5, the normalised size and the unmodified write data. Dropped accesses issue no request.
- R8: A response stays valid, with stable data, until it is acknowledged. The request ready stays low from acceptance until the acknowledge.
- R9: IO ports outside the address port and the window, and non-dword accesses to the address port, return all-ones of the access size on read. Writes to them leave the latch and the configuration side untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_valid | input | 1 | IO request present |
| io_req_ready | output | 1 | Bridge idle and accepting a request |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_port | input | IO_AW | IO port address |
| io_req_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| io_req_wdata | input | 32 | Write data, right-justified |
| io_rsp_valid | output | 1 | Response available |
| io_rsp_rdata | output | 32 | Read data (zero for writes) |
| io_rsp_ack | input | 1 | Host takes the response |
| fn_present | input | NUM_FN | Presence flag per device/function number |
| cfg_valid | output | 1 | Configuration request strobe |
| cfg_write | output | 1 | Configuration request is a write |
| cfg_devfn | output | 8 | Target device/function number |
| cfg_reg | output | 8 | Target register offset |
| cfg_size | output | 2 | Normalised access size (0, 1, 2) |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rvalid | input | 1 | Single-cycle read completion from target |
| cfg_rdata | input | 32 | Target read data, right-justified |

## Verification
The assertions check these properties on every cycle: the response is held stable until it is acknowledged, and ready is low while a response waits. Every configuration strobe lasts one cycle, and it appears only with the enable bit set and the bridge's own bus number latched. Its offset keeps the latched upper six bits, and a dword offset is aligned. The assertions cannot see whether a request should have been issued at all, or what data comes back. The bench sweeps enable, bus, device/function, offset, size and window offset against a target model. That sweep shows the miss results, the forced presence of numbers 0 and 8, the offset merge, the data masking and the absence of requests on misses.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_RSVD  = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      ACT_LATCH_WR,
      ACT_LATCH_RD,
      ACT_FWD,
      ACT_MISS
   } req_act_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_RESP
   } br_state_e;

   typedef struct packed {
      logic        write;
      logic [7:0]  devfn;
      logic [7:0]  reg_off;
      logic [1:0]  size;
      logic [31:0] wdata;
   } cfg_cmd_t;

   function automatic logic [31:0] size_ones(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_ones = 32'h0000_00FF;
         SZ_WORD: size_ones = 32'h0000_FFFF;
         default: size_ones = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/cfgbr_present.sv
module cfgbr_present #(
   parameter int unsigned NUM_FN     = 256,
   parameter int unsigned HOST_DEVFN = 0,
   parameter int unsigned AUX_DEVFN  = 8
) (
   input  logic [NUM_FN-1:0] fn_present,
   output logic [255:0]      present_eff
);
   for (genvar g = 0; g < 256; g++) begin : g_fn
      if (g == HOST_DEVFN || g == AUX_DEVFN) begin : g_fixed
         assign present_eff[g] = 1'b1;
      end else if (g < NUM_FN) begin : g_ext
         assign present_eff[g] = fn_present[g];
      end else begin : g_none
         assign present_eff[g] = 1'b0;
      end
   end
endmodule

// File: rtl/cfgbr_decode.sv
module cfgbr_decode
   import cfgbr_pkg::*;
#(
   parameter int unsigned          IO_AW     = 16,
   parameter logic [IO_AW-1:0]     ADDR_PORT = 'hCF8,
   parameter logic [IO_AW-1:0]     DATA_PORT = 'hCFC,
   parameter logic [7:0]           OWN_BUS   = 8'h00
) (
   input  logic             lat_en,
   input  logic [7:0]       lat_bus,
   input  logic [7:0]       lat_devfn,
   input  logic [7:0]       lat_reg,
   input  logic [255:0]     present_eff,
   input  logic             req_write,
   input  logic [IO_AW-1:0] req_port,
   input  logic [1:0]       req_size,
   input  logic [31:0]      req_wdata,
   output req_act_e         act,
   output cfg_cmd_t         cmd
);
   localparam int unsigned WHI = IO_AW - 1;

   logic [1:0] size_n;
   logic       hit_addr;
   logic       in_window;
   logic       target_ok;

   always_comb begin
      size_n    = (req_size == SZ_RSVD) ? SZ_DWORD : req_size;
      hit_addr  = (req_port == ADDR_PORT) && (size_n == SZ_DWORD);
      in_window = (req_port[WHI:2] == DATA_PORT[WHI:2]);
      target_ok = lat_en && (lat_bus == OWN_BUS) && present_eff[lat_devfn];

      cmd.write = req_write;
      cmd.devfn = lat_devfn;
      cmd.size  = size_n;
      cmd.wdata = req_wdata;
      if (size_n == SZ_DWORD)
         cmd.reg_off = {lat_reg[7:2], 2'b00};
      else
         cmd.reg_off = lat_reg | {6'b0, req_port[1:0]};

      if (hit_addr)
         act = req_write ? ACT_LATCH_WR : ACT_LATCH_RD;
      else if (in_window && target_ok)
         act = ACT_FWD;
      else
         act = ACT_MISS;
   end
endmodule

// File: rtl/cfgbr_ctrl.sv
module cfgbr_ctrl
   import cfgbr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  req_act_e    act,
   input  cfg_cmd_t    cmd,
   input  logic [31:0] latch_q,
   output logic        req_ready,
   output logic        latch_we,
   output logic        cfg_valid,
   output cfg_cmd_t    cmd_q,
   input  logic        cfg_rvalid,
   input  logic [31:0] cfg_rdata,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata,
   input  logic        rsp_ack
);
   br_state_e   state;
   logic [31:0] rsp_q;

   assign req_ready = (state == ST_IDLE);
   assign latch_we  = req_ready && req_valid && (act == ACT_LATCH_WR);
   assign cfg_valid = (state == ST_ISSUE);
   assign rsp_valid = (state == ST_RESP);
   assign rsp_rdata = rsp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cmd_q <= '0;
         rsp_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               cmd_q <= cmd;
               case (act)
                  ACT_FWD: state <= ST_ISSUE;
                  ACT_LATCH_RD: begin
                     rsp_q <= latch_q;
                     state <= ST_RESP;
                  end
                  ACT_MISS: begin
                     rsp_q <= cmd.write ? 32'h0 : size_ones(cmd.size);
                     state <= ST_RESP;
                  end
                  default: begin
                     rsp_q <= 32'h0;
                     state <= ST_RESP;
                  end
               endcase
            end
            ST_ISSUE: begin
               if (cmd_q.write) begin
                  rsp_q <= 32'h0;
                  state <= ST_RESP;
               end else begin
                  state <= ST_WAIT;
               end
            end
            ST_WAIT: if (cfg_rvalid) begin
               rsp_q <= cfg_rdata & size_ones(cmd_q.size);
               state <= ST_RESP;
            end
            default: if (rsp_ack) state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfg_portbridge.sv
module cfg_portbridge
   import cfgbr_pkg::*;
#(
   parameter int unsigned      IO_AW      = 16,
   parameter logic [IO_AW-1:0] ADDR_PORT  = 'hCF8,
   parameter logic [IO_AW-1:0] DATA_PORT  = 'hCFC,
   parameter logic [7:0]       OWN_BUS    = 8'h00,
   parameter int unsigned      NUM_FN     = 256,
   parameter int unsigned      HOST_DEVFN = 0,
   parameter int unsigned      AUX_DEVFN  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_req_valid,
   output logic              io_req_ready,
   input  logic              io_req_write,
   input  logic [IO_AW-1:0]  io_req_port,
   input  logic [1:0]        io_req_size,
   input  logic [31:0]       io_req_wdata,
   output logic              io_rsp_valid,
   output logic [31:0]       io_rsp_rdata,
   input  logic              io_rsp_ack,
   input  logic [NUM_FN-1:0] fn_present,
   output logic              cfg_valid,
   output logic              cfg_write,
   output logic [7:0]        cfg_devfn,
   output logic [7:0]        cfg_reg,
   output logic [1:0]        cfg_size,
   output logic [31:0]       cfg_wdata,
   input  logic              cfg_rvalid,
   input  logic [31:0]       cfg_rdata
);
   if (NUM_FN < 1 || NUM_FN > 256) begin : g_bad_fn
      $error("NUM_FN must lie in 1..256");
   end
   if (HOST_DEVFN > 255 || AUX_DEVFN > 255) begin : g_bad_fixed
      $error("fixed device/function numbers must fit in 8 bits");
   end
   if (IO_AW < 3) begin : g_bad_aw
      $error("IO_AW too small");
   end
   if (ADDR_PORT[1:0] != 2'b00 || DATA_PORT[1:0] != 2'b00) begin : g_bad_align
      $error("ports must be dword aligned");
   end

   logic [31:0]  addr_latch;
   logic [255:0] present_eff;
   req_act_e     act;
   cfg_cmd_t     cmd;
   cfg_cmd_t     cmd_q;
   logic         latch_we;

   always_ff @(posedge clk) begin
      if (!rst_n)        addr_latch <= 32'h0;
      else if (latch_we) addr_latch <= io_req_wdata;
   end

   cfgbr_present #(
      .NUM_FN(NUM_FN), .HOST_DEVFN(HOST_DEVFN), .AUX_DEVFN(AUX_DEVFN)
   ) u_present (
      .fn_present (fn_present),
      .present_eff(present_eff)
   );

   cfgbr_decode #(
      .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT), .OWN_BUS(OWN_BUS)
   ) u_decode (
      .lat_en     (addr_latch[31]),
      .lat_bus    (addr_latch[23:16]),
      .lat_devfn  (addr_latch[15:8]),
      .lat_reg    (addr_latch[7:0]),
      .present_eff(present_eff),
      .req_write  (io_req_write),
      .req_port   (io_req_port),
      .req_size   (io_req_size),
      .req_wdata  (io_req_wdata),
      .act        (act),
      .cmd        (cmd)
   );

   cfgbr_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (io_req_valid),
      .act       (act),
      .cmd       (cmd),
      .latch_q   (addr_latch),
      .req_ready (io_req_ready),
      .latch_we  (latch_we),
      .cfg_valid (cfg_valid),
      .cmd_q     (cmd_q),
      .cfg_rvalid(cfg_rvalid),
      .cfg_rdata (cfg_rdata),
      .rsp_valid (io_rsp_valid),
      .rsp_rdata (io_rsp_rdata),
      .rsp_ack   (io_rsp_ack)
   );

   assign cfg_write = cmd_q.write;
   assign cfg_devfn = cmd_q.devfn;
   assign cfg_reg   = cmd_q.reg_off;
   assign cfg_size  = cmd_q.size;
   assign cfg_wdata = cmd_q.wdata;
endmodule

// File: rtl/cfgbr_chk.sv
module cfgbr_chk #(
   parameter logic [7:0] OWN_BUS = 8'h00
) (
   input logic        clk,
   input logic        rst_n,
   input logic        io_req_ready,
   input logic        io_rsp_valid,
   input logic [31:0] io_rsp_rdata,
   input logic        io_rsp_ack,
   input logic        cfg_valid,
   input logic [7:0]  cfg_reg,
   input logic [1:0]  cfg_size,
   input logic        lat_en,
   input logic [7:0]  lat_bus,
   input logic [5:0]  lat_reg_hi
);
   // R8
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_rsp_valid && !io_rsp_ack |=> io_rsp_valid && $stable(io_rsp_rdata));
   // R8
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_rsp_valid |-> !io_req_ready);
   // R7
   cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> !cfg_valid);
   // R2
   cfg_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> lat_en);
   // R3
   cfg_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> lat_bus == OWN_BUS);
   // R5
   dword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid && cfg_size == 2'd2 |-> cfg_reg[1:0] == 2'b00);
   // R5
   reg_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> cfg_reg[7:2] == lat_reg_hi);
endmodule

bind cfg_portbridge cfgbr_chk #(.OWN_BUS(OWN_BUS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_req_ready(io_req_ready),
   .io_rsp_valid(io_rsp_valid),
   .io_rsp_rdata(io_rsp_rdata),
   .io_rsp_ack  (io_rsp_ack),
   .cfg_valid   (cfg_valid),
   .cfg_reg     (cfg_reg),
   .cfg_size    (cfg_size),
   .lat_en      (addr_latch[31]),
   .lat_bus     (addr_latch[23:16]),
   .lat_reg_hi  (addr_latch[7:2])
);

// File: tb/sim_cfg_portbridge.sv
`timescale 1ns/1ps
module sim_cfg_portbridge;
   localparam int TGT_LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_req_valid = 1'b0;
   logic        io_req_ready;
   logic        io_req_write = 1'b0;
   logic [15:0] io_req_port = 16'h0;
   logic [1:0]  io_req_size = 2'd0;
   logic [31:0] io_req_wdata = 32'h0;
   logic        io_rsp_valid;
   logic [31:0] io_rsp_rdata;
   logic        io_rsp_ack = 1'b0;
   logic [255:0] fn_present;
   logic        cfg_valid, cfg_write;
   logic [7:0]  cfg_devfn, cfg_reg;
   logic [1:0]  cfg_size;
   logic [31:0] cfg_wdata;
   logic        cfg_rvalid = 1'b0;
   logic [31:0] cfg_rdata = 32'h0;

   always #2.5 clk = ~clk;

   cfg_portbridge u0 (.*);

   int tests = 0, fails = 0, hold_bad = 0, cycles = 0;

   // target model and request monitor
   int          req_cnt = 0, pend = 0;
   logic        last_wr;
   logic [7:0]  last_devfn, last_reg;
   logic [1:0]  last_size;
   logic [31:0] last_wdata;

   function automatic logic [31:0] tgt_data(input logic [7:0] d, input logic [7:0] r);
      return {r, d, ~r, d ^ 8'h5A};
   endfunction
   function automatic logic [31:0] ones(input logic [1:0] s);
      return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction
   function automatic bit pres(input logic [7:0] d);
      return (d % 3 == 0) || d == 8'd8;
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      cfg_rvalid <= 1'b0;
      if (cfg_valid) begin
         req_cnt    <= req_cnt + 1;
         last_wr    <= cfg_write;
         last_devfn <= cfg_devfn;
         last_reg   <= cfg_reg;
         last_size  <= cfg_size;
         last_wdata <= cfg_wdata;
         if (!cfg_write) pend <= TGT_LAT;
      end else if (pend > 0) begin
         pend <= pend - 1;
         if (pend == 1) begin
            cfg_rvalid <= 1'b1;
            cfg_rdata  <= tgt_data(last_devfn, last_reg);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [15:0] port, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd);
      int w;
      @(negedge clk);
      io_req_valid = 1'b1; io_req_write = wr; io_req_port = port;
      io_req_size = sz; io_req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      io_req_valid = 1'b0;
      w = 0;
      while (!io_rsp_valid && w < 50) begin @(negedge clk); w++; end
      rd = io_rsp_rdata;
      @(negedge clk);
      if (!io_rsp_valid || io_rsp_rdata != rd || io_req_ready) hold_bad++;
      io_rsp_ack = 1'b1;
      @(negedge clk);
      io_rsp_ack = 1'b0;
   endtask

   initial begin
      logic [31:0] rd, exp;
      logic [7:0] dl [8] = '{8'd0, 8'd1, 8'd3, 8'd7, 8'd8, 8'd9, 8'd16, 8'd255};
      logic [7:0] rl [4] = '{8'h00, 8'h3D, 8'h43, 8'hFE};
      logic [7:0] bl [3] = '{8'h00, 8'h01, 8'h80};
      for (int d = 0; d < 256; d++) fn_present[d] = (d % 3 == 0) && d != 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      xfer(0, 16'hCF8, 2, 0, rd);
      chk(rd == 0, "R2 latch reset", rd, 0);
      xfer(0, 16'hCFC, 0, 0, rd);
      chk(rd == 32'hFF, "R2 disabled byte read", rd, 32'hFF);

      // R1 latch round trip
      xfer(1, 16'hCF8, 2, 32'h7F3C_A5C3, rd);
      xfer(0, 16'hCF8, 2, 0, rd);
      chk(rd == 32'h7F3C_A5C3, "R1 latch readback", rd, 32'h7F3C_A5C3);

      // R9 unmapped ports and narrow address-port access
      xfer(1, 16'hCF8, 1, 32'h8000_0000, rd);
      xfer(1, 16'hCF9, 0, 32'hFF, rd);
      xfer(0, 16'hCF8, 2, 0, rd);
      chk(rd == 32'h7F3C_A5C3, "R9 narrow write ignored", rd, 32'h7F3C_A5C3);
      xfer(0, 16'hCF9, 0, 0, rd);
      chk(rd == 32'hFF, "R9 narrow read", rd, 32'hFF);
      xfer(0, 16'h0080, 2, 0, rd);
      chk(rd == 32'hFFFF_FFFF, "R9 other port read", rd, 32'hFFFF_FFFF);
      xfer(0, 16'hCF4, 1, 0, rd);
      chk(rd == 32'hFFFF, "R9 other port word", rd, 32'hFFFF);

      // sweep
      for (int en = 0; en < 2; en++)
      for (int bi = 0; bi < 3; bi++)
      for (int di = 0; di < 8; di++)
      for (int ri = 0; ri < 4; ri++) begin
         logic [31:0] lat;
         bit fwd;
         string why;
         lat = {en[0], 7'h0, bl[bi], dl[di], rl[ri]};
         fwd = en != 0 && bl[bi] == 8'h00 && pres(dl[di]);
         why = (en == 0) ? "R2" : (bl[bi] != 0) ? "R3" : !pres(dl[di]) ? "R4" : "R6";
         xfer(1, 16'hCF8, 2, lat, rd);
         for (int sz = 0; sz < 4; sz++)
         for (int off = 0; off < ((sz >= 2) ? 1 : 4); off++) begin
            logic [7:0] re;
            logic [1:0] szn;
            int c0;
            szn = (sz >= 2) ? 2'd2 : sz[1:0];
            re = (szn == 2'd2) ? {rl[ri][7:2], 2'b00} : (rl[ri] | off[7:0]);
            exp = fwd ? (tgt_data(dl[di], re) & ones(szn)) : ones(szn);
            c0 = req_cnt;
            xfer(0, 16'hCFC + off[15:0], sz[1:0], 0, rd);
            chk(rd == exp, why, rd, exp);
            if (fwd) chk(last_reg == re && last_devfn == dl[di], "R5 offset", {24'h0, last_reg}, {24'h0, re});
            c0 = req_cnt;
            xfer(1, 16'hCFC + off[15:0], sz[1:0], 32'hC0DE_0000 | {16'h0, lat[15:0]}, rd);
            if (fwd)
               chk(req_cnt == c0 + 1 && last_wr && last_reg == re && last_size == szn &&
                   last_wdata == (32'hC0DE_0000 | {16'h0, lat[15:0]}),
                   "R7 forwarded write", last_wdata, 32'hC0DE_0000 | {16'h0, lat[15:0]});
            else
               chk(req_cnt == c0, "R7 dropped write", req_cnt - c0, 0);
         end
      end

      chk(hold_bad == 0, "R8 response hold", hold_bad, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wait (cycles > 190000);
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule